// File: doc/BRIEF.md
# Multiply-Accumulate Unit with 40-Bit Accumulator

This unit multiplies two 16-bit operands in a single clock cycle and, depending on the selected operation, either loads the product into a 40-bit accumulator or adds it to or subtracts it from the value already held there. Either operand can be read as a two's-complement number or as an unsigned number. A mode input chooses how the product is aligned. In fractional alignment the product is doubled, which drops the redundant sign bit of a signed fractional product. In integer alignment the product is taken as it stands.

The 40-bit accumulator has eight guard bits above the 32-bit product. It is presented as three sections: a low word, a high word and an 8-bit extension. A destination bit sends the result of an operation either into the accumulator or into a 16-bit feedback register. The feedback register receives the high word of the result, and the accumulator is left as it was. A flag tells the surrounding datapath when the accumulator value no longer fits a 32-bit signed range. Each operation is issued by pulsing an enable for one cycle, and its result is visible after the next rising clock edge.

Top module: `mac_unit`

## Requirements
- R1: While rst_n is low the accumulator sections, the feedback register and the overflow flag all read zero, and they still read zero in the first cycle after reset is released.
- R2: One cycle after an enabled plain multiply, the accumulator holds the aligned product, and its previous contents are discarded.
- R3: The operation code is decoded as 2'b00 plain multiply, 2'b01 accumulator plus product, 2'b10 accumulator minus product, and 2'b11 plain multiply.
- R4: x_signed and y_signed, each set to 1, make x_in and y_in respectively two's-complement values. Set to 0, the operand is unsigned. The 32-bit product is exact for all four combinations.
- R5: Before accumulation the 32-bit product is sign-extended to 40 bits when at least one operand is signed, and zero-extended when both operands are unsigned.
- R6: With int_mode = 0 (fractional) the extended product is shifted left by one bit, and bit 0 of a plain multiply result is zero. With int_mode = 1 no shift takes place.
- R7: With dest_mf = 1 the feedback register takes bits 31:16 of the result and the accumulator keeps its value. With dest_mf = 0 the accumulator takes the result and the feedback register keeps its value.
- R8: Accumulation wraps modulo 2^40, and the result is never saturated.
- R9: ovf is 1 exactly when bits 39:31 of the current accumulator are not all equal.
- R10: With en = 0 the accumulator and the feedback register hold their values, whatever the other inputs do.
- R11: mr0 presents accumulator bits 15:0, mr1 presents bits 31:16 and mr2 presents bits 39:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Issues one operation in this cycle |
| op | input | 2 | Operation code (see R3) |
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| x_signed | input | 1 | 1: x_in is two's complement |
| y_signed | input | 1 | 1: y_in is two's complement |
| int_mode | input | 1 | 1: integer alignment, 0: fractional alignment |
| dest_mf | input | 1 | 1: result goes to the feedback register |
| mr0 | output | 16 | Accumulator bits 15:0 |
| mr1 | output | 16 | Accumulator bits 31:16 |
| mr2 | output | 8 | Accumulator bits 39:32 |
| mf | output | 16 | Feedback register |
| ovf | output | 1 | Accumulator exceeds the 32-bit signed range |

## Verification
The bench aims at the extension rule first. It tests an all-ones unsigned product, which a unit that sign-extends wrongly would turn negative in mr2. It also tests a signed-by-unsigned product, which a unit that zero-extends would show as a large positive value. Fractional and integer alignment are run on the same operands, so a missing or doubled shift produces a result off by a factor of two. A long run of accumulations carries the value past 2^39, which exposes any saturation, any change in the wrap point and any error in the guard-bit comparison behind ovf. Operations routed to the feedback register, and idle cycles with busy inputs, show whether the wrong register is written.

// File: rtl/mac_pkg.sv
// Package mac_pkg
// Shared operation encoding and default widths for the multiply-accumulate
// unit. Assumes a two-bit operation code, decoded by mac_accum.
package mac_pkg;
    localparam int MAC_OPW  = 16;
    localparam int MAC_ACCW = 40;

    typedef enum logic [1:0] {
        MAC_OP_MUL  = 2'b00,
        MAC_OP_ADD  = 2'b01,
        MAC_OP_SUB  = 2'b10,
        MAC_OP_MULB = 2'b11
    } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
// Module mac_mult
// Combinational OPW x OPW multiplier with an independent signedness choice
// for each operand. Each operand is widened by one bit: the sign bit when
// the operand is signed, zero when it is not. The product is then formed
// as a signed value, and its low 2*OPW bits are exact for every mix.
module mac_mult #(
    parameter int OPW = 16
) (
    input  logic [OPW-1:0]   a,
    input  logic [OPW-1:0]   b,
    input  logic             a_signed,
    input  logic             b_signed,
    output logic [2*OPW-1:0] prod
);
    localparam int PW   = 2 * OPW;
    localparam int FULW = 2 * (OPW + 1);

    logic signed [OPW:0]    a_ext;
    logic signed [OPW:0]    b_ext;
    logic signed [FULW-1:0] full;

    // Widen each operand by its sign bit or by zero.
    always_comb begin
        a_ext = {a_signed & a[OPW-1], a};
        b_ext = {b_signed & b[OPW-1], b};
    end

    // Signed product of the widened operands; keep the exact low part.
    always_comb begin
        full = a_ext * b_ext;
        prod = full[PW-1:0];
    end
endmodule

// File: rtl/mac_align.sv
// Module mac_align
// Extends the product to accumulator width and applies the alignment for
// the selected format. The extension is by sign when ext_signed is set and
// by zero otherwise. Fractional alignment doubles the value, and the top
// bit falls off modulo 2^ACCW.
module mac_align #(
    parameter int OPW  = 16,
    parameter int ACCW = 40
) (
    input  logic [2*OPW-1:0] prod,
    input  logic             ext_signed,
    input  logic             int_mode,
    output logic [ACCW-1:0]  aligned
);
    localparam int PW    = 2 * OPW;
    localparam int GUARD = ACCW - PW;

    logic [ACCW-1:0] widened;

    // Fill the guard bits with the product sign or with zero.
    always_comb begin
        widened = {{GUARD{ext_signed & prod[PW-1]}}, prod};
    end

    // Fractional alignment shifts left by one; integer leaves it.
    always_comb begin
        aligned = int_mode ? widened : {widened[ACCW-2:0], 1'b0};
    end
endmodule

// File: rtl/mac_accum.sv
// Module mac_accum
// Holds the accumulator and the feedback register. Combines the aligned
// product with the accumulator as the operation code asks, wraps modulo
// 2^ACCW, and writes one of the two registers when en is high.
// The feedback register takes MFW bits starting at bit MF_LSB.
module mac_accum
    import mac_pkg::*;
#(
    parameter int ACCW   = 40,
    parameter int MFW    = 16,
    parameter int MF_LSB = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [1:0]      op,
    input  logic            dest_mf,
    input  logic [ACCW-1:0] addend,
    output logic [ACCW-1:0] acc_q,
    output logic [MFW-1:0]  fb_q
);
    logic [ACCW-1:0] result;

    // Select load, add or subtract of the aligned product.
    always_comb begin
        unique case (mac_op_e'(op))
            MAC_OP_ADD: result = acc_q + addend;
            MAC_OP_SUB: result = acc_q - addend;
            default:    result = addend;
        endcase
    end

    // Accumulator register: cleared on reset, written when routed here.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (en && !dest_mf)
            acc_q <= result;
    end

    // Feedback register: cleared on reset, takes the result's high word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fb_q <= '0;
        else if (en && dest_mf)
            fb_q <= result[MF_LSB +: MFW];
    end
endmodule

// File: rtl/mac_unit.sv
// Module mac_unit (top)
// Single-cycle multiply-accumulate unit with a 40-bit accumulator and a
// 16-bit feedback register. The accumulator is presented as three
// sections, and ovf reports when its value leaves the 32-bit signed range.
// Assumes one operation per enabled cycle; inputs are sampled at the edge.
module mac_unit
    import mac_pkg::*;
#(
    parameter int OPW  = MAC_OPW,
    parameter int ACCW = MAC_ACCW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [1:0]           op,
    input  logic [OPW-1:0]       x_in,
    input  logic [OPW-1:0]       y_in,
    input  logic                 x_signed,
    input  logic                 y_signed,
    input  logic                 int_mode,
    input  logic                 dest_mf,
    output logic [OPW-1:0]       mr0,
    output logic [OPW-1:0]       mr1,
    output logic [ACCW-2*OPW-1:0] mr2,
    output logic [OPW-1:0]       mf,
    output logic                 ovf
);
    localparam int PW    = 2 * OPW;
    localparam int GUARD = ACCW - PW;

    logic [PW-1:0]   prod;
    logic [ACCW-1:0] aligned;
    logic [ACCW-1:0] acc;
    logic [GUARD:0]  top_bits;

    mac_mult #(.OPW(OPW)) u_mult (
        .a        (x_in),
        .b        (y_in),
        .a_signed (x_signed),
        .b_signed (y_signed),
        .prod     (prod)
    );

    mac_align #(.OPW(OPW), .ACCW(ACCW)) u_align (
        .prod       (prod),
        .ext_signed (x_signed | y_signed),
        .int_mode   (int_mode),
        .aligned    (aligned)
    );

    mac_accum #(.ACCW(ACCW), .MFW(OPW), .MF_LSB(OPW)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .op      (op),
        .dest_mf (dest_mf),
        .addend  (aligned),
        .acc_q   (acc),
        .fb_q    (mf)
    );

    // Split the accumulator into its three visible sections.
    always_comb begin
        mr0 = acc[OPW-1:0];
        mr1 = acc[PW-1:OPW];
        mr2 = acc[ACCW-1:PW];
    end

    // Guard bits plus the product sign must agree for an in-range value.
    always_comb begin
        top_bits = acc[ACCW-1:PW-1];
        ovf      = !((&top_bits) || !(|top_bits));
    end
endmodule

// File: rtl/mac_checker.sv
// Module mac_checker
// Property checks for mac_unit, attached through bind. Relates the issued
// command to the register contents one cycle later.
module mac_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic [1:0]  op,
    input logic        x_signed,
    input logic        y_signed,
    input logic        int_mode,
    input logic        dest_mf,
    input logic [15:0] mr0,
    input logic [15:0] mr1,
    input logic [7:0]  mr2,
    input logic [15:0] mf
);
    logic is_mul;
    assign is_mul = (op == 2'b00) || (op == 2'b11);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> ({mr2, mr1, mr0} == 40'd0 && mf == 16'd0));

    assert_mf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en && !dest_mf |=> $stable(mf));

    assert_mr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en && dest_mf |=> $stable({mr2, mr1, mr0}));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable({mr2, mr1, mr0}) && $stable(mf)));

    assert_zero_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en && !dest_mf && is_mul && int_mode && !x_signed && !y_signed
        |=> mr2 == 8'd0);

    assert_sign_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en && !dest_mf && is_mul && int_mode && (x_signed || y_signed)
        |=> mr2 == {8{mr1[15]}});

    assert_frac_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en && !dest_mf && is_mul && !int_mode |=> mr0[0] == 1'b0);
endmodule

bind mac_unit mac_checker u_mac_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .op       (op),
    .x_signed (x_signed),
    .y_signed (y_signed),
    .int_mode (int_mode),
    .dest_mf  (dest_mf),
    .mr0      (mr0),
    .mr1      (mr1),
    .mr2      (mr2),
    .mf       (mf)
);

// File: tb/tb_mac_unit.sv
// Scoreboard bench for mac_unit: the driver task issues one command per
// cycle and queues the expected state; the monitor compares at negedges.
module tb_mac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [15:0] x_in = '0;
    logic [15:0] y_in = '0;
    logic        x_signed = 1'b0;
    logic        y_signed = 1'b0;
    logic        int_mode = 1'b0;
    logic        dest_mf = 1'b0;
    logic [15:0] mr0, mr1, mf;
    logic [7:0]  mr2;
    logic        ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [39:0] mr;
        logic [15:0] mf;
        logic        ovf;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [39:0] m_mr = '0;
    logic [15:0] m_mf = '0;

    always #4 clk = ~clk;

    mac_unit dut (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .x_in(x_in), .y_in(y_in),
        .x_signed(x_signed), .y_signed(y_signed), .int_mode(int_mode),
        .dest_mf(dest_mf), .mr0(mr0), .mr1(mr1), .mr2(mr2), .mf(mf), .ovf(ovf)
    );

    function automatic logic exp_ovf(input logic [39:0] v);
        return !((v[39:31] == 9'h1FF) || (v[39:31] == 9'h000));
    endfunction

    // Exact product from the operand meanings, then the alignment factor.
    function automatic logic [39:0] model_prod(input logic [15:0] x, y,
                                               input logic xs, ys, im);
        longint xv = xs ? longint'($signed(x)) : longint'(x);
        longint yv = ys ? longint'($signed(y)) : longint'(y);
        longint p  = xv * yv;
        if (!im) p = p * 2;
        return p[39:0];
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [39:0] act, input logic [39:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic issue(input logic e, input logic [1:0] o,
                         input logic [15:0] x, y, input logic xs, ys, im, dm,
                         input string tag);
        logic [39:0] p;
        logic [39:0] r;
        exp_t it;
        @(negedge clk);
        en = e; op = o; x_in = x; y_in = y;
        x_signed = xs; y_signed = ys; int_mode = im; dest_mf = dm;
        if (e) begin
            p = model_prod(x, y, xs, ys, im);
            case (o)
                2'b01:   r = m_mr + p;
                2'b10:   r = m_mr - p;
                default: r = p;
            endcase
            if (dm) m_mf = r[31:16];
            else    m_mr = r;
        end
        @(posedge clk);
        #1;
        it.mr = m_mr; it.mf = m_mf; it.ovf = exp_ovf(m_mr); it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare the oldest expectation with the ports.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            check(it.tag, "mr (R11 sections)", {mr2, mr1, mr0}, it.mr);
            check(it.tag, "mf", {24'd0, mf}, {24'd0, it.mf});
            check({it.tag, "/R9"}, "ovf", {39'd0, ovf}, {39'd0, it.ovf});
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "mr in reset", {mr2, mr1, mr0}, 40'd0);
        check("R1", "mf in reset", {24'd0, mf}, 40'd0);
        check("R1", "ovf in reset", {39'd0, ovf}, 40'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "mr after release", {mr2, mr1, mr0}, 40'd0);

        issue(1, 2'b00, 16'd3, 16'd5, 0, 0, 1, 0, "R2");
        issue(1, 2'b00, 16'hFFFE, 16'd3, 1, 1, 1, 0, "R4");
        issue(1, 2'b00, 16'hFFFF, 16'hFFFF, 1, 0, 1, 0, "R5");
        issue(1, 2'b00, 16'hFFFF, 16'hFFFF, 0, 0, 1, 0, "R5");
        issue(1, 2'b00, 16'hFFFF, 16'hFFFF, 1, 1, 1, 0, "R4");
        issue(1, 2'b00, 16'h4000, 16'h4000, 1, 1, 0, 0, "R6");
        issue(1, 2'b00, 16'h4000, 16'h4000, 1, 1, 1, 0, "R6");
        issue(1, 2'b00, 16'h8000, 16'h8000, 1, 1, 0, 0, "R9");
        issue(1, 2'b11, 16'd7, 16'd9, 0, 0, 1, 0, "R3");
        issue(1, 2'b01, 16'd100, 16'd100, 0, 0, 1, 0, "R3");
        issue(1, 2'b10, 16'd50, 16'd4, 0, 0, 1, 0, "R3");
        issue(1, 2'b10, 16'h7FFF, 16'h7FFF, 1, 1, 1, 0, "R3");
        issue(1, 2'b01, 16'h1234, 16'h0100, 0, 0, 1, 1, "R7");
        issue(1, 2'b00, 16'hABCD, 16'h8765, 1, 0, 0, 1, "R7");
        issue(0, 2'b00, 16'hFFFF, 16'h1111, 1, 1, 0, 0, "R10");
        issue(0, 2'b01, 16'h2222, 16'h3333, 0, 1, 1, 1, "R10");

        // Long run of large fractional products: crosses 2^39 and wraps.
        issue(1, 2'b00, 16'd0, 16'd0, 0, 0, 1, 0, "R8");
        for (int i = 0; i < 600; i++)
            issue(1, 2'b01, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, "R8");
        for (int i = 0; i < 300; i++)
            issue(1, 2'b10, 16'h8000, 16'h7FFF, 1, 1, 0, 0, "R8");

        for (int i = 0; i < 300; i++)
            issue($urandom_range(0, 4) != 0, 2'($urandom), 16'($urandom),
                  16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), "R3");

        repeat (3) @(negedge clk);
        check("R2", "scoreboard drained", {8'd0, 32'(sb.size())}, 40'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule